// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Deferred Delivery

This block gathers level-sensitive interrupt sources into groups and gives each group one request line toward an upstream interrupt controller. Each group has two registers on a simple 32-bit register bus. The first is an enable register that also serves as a mask and unmask control while an interrupt is being serviced. The second is a status register that tells firmware which sources fired.

When the OR of a group's sources rises, the enabled sources are evaluated once. If the group is idle, they are latched into status and the request line goes high. If the group is busy (status still nonzero, or some enable bits masked), they are collected in a hidden pending word instead. Firmware acknowledges a source by writing ones to its status bits. When a partial acknowledge drains status to zero, the held pending word is moved into status and the line stays high. If nothing is held, the line drops. A write of all ones clears status only, as an initialisation step, and replays nothing.

Group `g` decodes at byte address `0x1000 + 0x100*g` for enable and `0x1004 + 0x100*g` for status. The group index comes from address bits [11:8]. The register window spans `0x0000` to `0x1FFF`. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `intc_agg`

## Requirements
- R1: After reset, every enable and status register reads 0, every request line is low, and all hidden enable, mask and pending words are zero.
- R2: Group g's enable register is at byte address 0x1000+0x100*g and reads back the last value written there. Its status register is at that address plus 4 and reads the status bits zero-extended to 32 bits. Read data appears on `rdata_o` one clock after `rd_en_i`.
- R3: When the OR of a group's sources rises while the group is idle (mask word zero and status zero), status is loaded with the sources that are both active and enabled. The group's request line is high one clock after the rising source.
- R4: If the rising sources include no enabled source, status, pending and the request line are left unchanged.
- R5: If a rise arrives while status is nonzero or the mask word is nonzero, the enabled active sources are ORed into the hidden pending word, and status and the request line are unchanged. A status write other than all ones that leaves status at zero does the following: if pending is nonzero, pending moves into status, pending is cleared and the line stays high; otherwise the line drops.
- R6: A status write of 0xFFFFFFFF clears status. It leaves the pending word and the request line unchanged.
- R7: The hidden enable word accumulates: each enable write ORs the data into it, and no write clears it. A write that adds new bits only stores the data.
- R8: An enable write that adds no new bits forms change = stored value XOR data. If change AND data is nonzero, the change bits are removed from the mask word (unmask). Otherwise they are added to the mask word (mask). The data is then stored.
- R9: Writing zero to an enable register while the hidden enable word is zero only stores the zero and leaves the mask word unchanged.
- R10: Reads of any address that is not an implemented register return 0. Writes to such addresses have no effect. This includes addresses at or above 0x2000, other offsets inside a group, and group indices at or above the group count.
- R11: A source event is evaluated only on the rising edge of its group's OR. Sources that are held high, or that become active while the OR is already high, trigger nothing further.
- R12: When a status write and a source rise occur in the same clock, the write takes effect first and the rise is then evaluated against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, one clock per write |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| src_i | input | NGRP*NSRC | Source lines, group g occupying bits [g*NSRC +: NSRC] |
| irq_o | output | NGRP | One request line per group |

## Verification
The bench builds the block with NGRP=3 and NSRC=8. With these values every source of every group can be swept one at a time, confirming that the right status bit and the right request line respond. The small configuration also leaves an unused group index (3) inside the window for the decode checks. The scenarios drive groups through the busy paths: a held event replaying on drain, an all-ones clear that keeps pending, mask and unmask through enable rewrites, edge-only evaluation, and an acknowledge colliding with a new rise in the same clock.

// File: rtl/intc_agg_pkg.sv
package intc_agg_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned WIN_BITS  = 13;   // window is 2**13 bytes
  localparam int unsigned GRP_LSB   = 8;    // group index in addr[11:8]
  localparam int unsigned GRP_BITS  = 4;
  localparam int unsigned BASE_BIT  = 12;   // group registers live at 0x1000 and up
  localparam int unsigned ST_BIT    = 2;    // status sits 4 bytes above enable
endpackage

// File: rtl/intc_agg_dec.sv
module intc_agg_dec
  import intc_agg_pkg::*;
#(
  parameter int unsigned NGRP   = 9,
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NGRP-1:0]   grp_oh_o,
  output logic              en_hit_o,
  output logic              st_hit_o
);
  localparam int unsigned HI_W = ADDR_W - WIN_BITS;

  logic [GRP_BITS-1:0] grp_idx;
  logic                in_win;
  logic                valid;

  assign grp_idx = addr_i[GRP_LSB +: GRP_BITS];
  assign in_win  = (addr_i[ADDR_W-1:WIN_BITS] == HI_W'(0));
  assign valid   = in_win && addr_i[BASE_BIT]
                && ({1'b0, grp_idx} < (GRP_BITS+1)'(NGRP))
                && (addr_i[GRP_LSB-1:ST_BIT+1] == '0)
                && (addr_i[ST_BIT-1:0] == '0);
  assign en_hit_o = valid && !addr_i[ST_BIT];
  assign st_hit_o = valid &&  addr_i[ST_BIT];

  for (genvar g = 0; g < NGRP; g++) begin : g_oh
    assign grp_oh_o[g] = valid && (grp_idx == GRP_BITS'(g));
  end
endmodule

// File: rtl/intc_agg_grp.sv
module intc_agg_grp
  import intc_agg_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              en_wr_i,
  input  logic              st_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] en_reg_o,
  output logic [NSRC-1:0]   status_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] enr_q, enr_n;
  logic [NSRC-1:0]   acc_q, acc_n, mask_q, mask_n;
  logic [NSRC-1:0]   st_q, st_n, pend_q, pend_n;
  logic              irq_q, irq_n;
  logic              or_q, or_now, rise, upd;
  logic [DATA_W-1:0] chg;
  logic [NSRC-1:0]   sel;
  logic [NSRC-1:0]   wd_s;

  assign or_now = |src_i;
  assign rise   = or_now && !or_q;
  assign upd    = en_wr_i || st_wr_i || rise;
  assign wd_s   = wdata_i[NSRC-1:0];
  assign chg    = enr_q ^ wdata_i;

  // next state: bus write first, then the source event
  always_comb begin
    enr_n  = enr_q;
    acc_n  = acc_q;
    mask_n = mask_q;
    st_n   = st_q;
    pend_n = pend_q;
    irq_n  = irq_q;
    if (en_wr_i) begin
      enr_n = wdata_i;
      if (!((wdata_i == '0) && (acc_q == '0))) begin
        if ((acc_q | wd_s) != acc_q) begin
          acc_n = acc_q | wd_s;
        end else if ((chg & wdata_i) != '0) begin
          mask_n = mask_q & ~chg[NSRC-1:0];
        end else begin
          mask_n = mask_q | chg[NSRC-1:0];
        end
      end
    end
    if (st_wr_i) begin
      st_n = st_q & ~wd_s;
      if ((wdata_i != '1) && (st_n == '0)) begin
        if (pend_q != '0) begin
          st_n   = pend_q;
          pend_n = '0;
          irq_n  = 1'b1;
        end else begin
          irq_n  = 1'b0;
        end
      end
    end
    sel = src_i & acc_n;
    if (rise && (sel != '0)) begin
      if ((mask_n != '0) || (st_n != '0)) begin
        pend_n = pend_n | sel;
      end else begin
        st_n  = sel;
        irq_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      or_q <= 1'b0;
    end else begin
      or_q <= or_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enr_q  <= '0;
      acc_q  <= '0;
      mask_q <= '0;
      st_q   <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else if (upd) begin
      enr_q  <= enr_n;
      acc_q  <= acc_n;
      mask_q <= mask_n;
      st_q   <= st_n;
      pend_q <= pend_n;
      irq_q  <= irq_n;
    end
  end

  assign en_reg_o = enr_q;
  assign status_o = st_q;
  assign irq_o    = irq_q;

  // R3
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> (st_q != '0));
  // R7
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_q & $past(acc_q)) == $past(acc_q)));
  // R5
  pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q == '0) && ($past(pend_q) != '0)) |-> $past(st_wr_i));
  // R5
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(st_wr_i));
endmodule

// File: rtl/intc_agg.sv
module intc_agg
  import intc_agg_pkg::*;
#(
  parameter int unsigned NGRP   = 9,
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 rd_en_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NGRP*NSRC-1:0] src_i,
  output logic [NGRP-1:0]      irq_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [NGRP-1:0]   grp_oh;
  logic              en_hit, st_hit, hit;
  logic [DATA_W-1:0] en_reg_a [NGRP];
  logic [NSRC-1:0]   st_a     [NGRP];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  intc_agg_dec #(.NGRP(NGRP), .ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .grp_oh_o (grp_oh),
    .en_hit_o (en_hit),
    .st_hit_o (st_hit)
  );
  assign hit = en_hit || st_hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    intc_agg_grp #(.NSRC(NSRC)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .src_i    (src_i[g*NSRC +: NSRC]),
      .en_wr_i  (wr_en_i && en_hit && grp_oh[g]),
      .st_wr_i  (wr_en_i && st_hit && grp_oh[g]),
      .wdata_i  (wdata_i),
      .en_reg_o (en_reg_a[g]),
      .status_o (st_a[g]),
      .irq_o    (irq_o[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_oh[g] && en_hit) rd_mux = en_reg_a[g];
      if (grp_oh[g] && st_hit) rd_mux = DATA_W'(st_a[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  // R10
  oow_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(rd_en_i) && !$past(hit)) |-> (rdata_o == '0));
  // R2
  grp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(grp_oh) && (hit == (grp_oh != '0)));
endmodule

// File: tb/sim_intc_agg.sv
module sim_intc_agg;
  localparam int unsigned NGRP   = 3;
  localparam int unsigned NSRC   = 8;
  localparam int unsigned ADDR_W = 16;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [ADDR_W-1:0]    addr;
  logic                 wr_en;
  logic [31:0]          wdata;
  logic                 rd_en;
  logic [31:0]          rdata;
  logic [NGRP*NSRC-1:0] src;
  logic [NGRP-1:0]      irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  intc_agg #(.NGRP(NGRP), .NSRC(NSRC), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  function automatic logic [15:0] en_a(int g);
    return 16'(32'h1000 + 32'h100 * g);
  endfunction
  function automatic logic [15:0] st_a(int g);
    return 16'(32'h1004 + 32'h100 * g);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic set_src(int g, logic [NSRC-1:0] v);
    src[g*NSRC +: NSRC] = v;
    tick();
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; src = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    do_reset();

    // R1 reset state
    for (int g = 0; g < NGRP; g++) begin
      chk_rd("R1 enable", en_a(g), 32'h0);
      chk_rd("R1 status", st_a(g), 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 address map readback
    wr(en_a(0), 32'hA5A5_00A5);
    chk_rd("R2 enable readback", en_a(0), 32'hA5A5_00A5);
    chk_rd("R2 status idle", st_a(0), 32'h0);

    // R9 zero write with empty enable word, group 2
    wr(en_a(2), 32'h0);
    chk_rd("R9 stored zero", en_a(2), 32'h0);
    wr(en_a(2), 32'h4);
    set_src(2, 8'h04);
    chk_rd("R9 no mask from zero write", st_a(2), 32'h4);
    chk("R9 irq", 32'(irq[2]), 32'h1);
    wr(st_a(2), 32'h4);
    set_src(2, 8'h00);

    // R4 / R7 / R8 on group 1
    wr(en_a(1), 32'h3);
    set_src(1, 8'h20);
    chk_rd("R4 unenabled source", st_a(1), 32'h0);
    chk("R4 irq low", 32'(irq[1]), 32'h0);
    set_src(1, 8'h00);
    set_src(1, 8'h01);
    chk_rd("R3 latch", st_a(1), 32'h1);
    wr(st_a(1), 32'h1);
    chk("R5 drop without pending", 32'(irq[1]), 32'h0);
    set_src(1, 8'h00);
    wr(en_a(1), 32'h0);                       // mask bits 0..1
    chk_rd("R8 stored data", en_a(1), 32'h0);
    set_src(1, 8'h02);
    chk_rd("R8 masked to pending", st_a(1), 32'h0);
    chk("R7 still enabled not raised", 32'(irq[1]), 32'h0);
    set_src(1, 8'h00);
    wr(en_a(1), 32'h3);                       // unmask
    chk_rd("R8 unmask no event", st_a(1), 32'h0);
    wr(st_a(1), 32'h0);                       // drain: replay pending
    chk_rd("R7 sticky enable held event", st_a(1), 32'h2);
    chk("R5 replay irq", 32'(irq[1]), 32'h1);
    wr(st_a(1), 32'h2);
    chk("R5 drained irq", 32'(irq[1]), 32'h0);

    // R3 sweep over every source of every group
    for (int g = 0; g < NGRP; g++) wr(en_a(g), 32'hFF);
    for (int g = 0; g < NGRP; g++) begin
      for (int b = 0; b < NSRC; b++) begin
        set_src(g, NSRC'(1) << b);
        chk("R3 irq line", 32'(irq), 32'(1) << g);
        chk_rd("R3 status bit", st_a(g), 32'(1) << b);
        wr(st_a(g), 32'(1) << b);
        chk("R3 irq cleared", 32'(irq), 32'h0);
        set_src(g, '0);
      end
    end

    // R5 pending while busy, group 0
    set_src(0, 8'h01);
    set_src(0, 8'h00);
    set_src(0, 8'h08);
    chk_rd("R5 status held", st_a(0), 32'h1);
    set_src(0, 8'h00);
    wr(st_a(0), 32'h1);
    chk_rd("R5 pending replayed", st_a(0), 32'h8);
    chk("R5 irq held", 32'(irq[0]), 32'h1);
    wr(st_a(0), 32'h8);
    chk("R5 irq dropped", 32'(irq[0]), 32'h0);

    // R6 all-ones clear
    set_src(0, 8'h02);
    set_src(0, 8'h00);
    set_src(0, 8'h10);
    set_src(0, 8'h00);
    wr(st_a(0), 32'hFFFF_FFFF);
    chk_rd("R6 status cleared", st_a(0), 32'h0);
    chk("R6 irq unchanged", 32'(irq[0]), 32'h1);
    set_src(0, 8'h20);
    chk_rd("R6 new event latched", st_a(0), 32'h20);
    set_src(0, 8'h00);
    wr(st_a(0), 32'h20);
    chk_rd("R6 pending kept then replayed", st_a(0), 32'h10);
    wr(st_a(0), 32'h10);
    chk("R6 final irq", 32'(irq[0]), 32'h0);

    // R11 edge-only evaluation, group 2
    set_src(2, 8'h01);
    wr(st_a(2), 32'h1);
    repeat (3) tick();
    chk_rd("R11 held source", st_a(2), 32'h0);
    set_src(2, 8'h03);
    chk_rd("R11 join while high", st_a(2), 32'h0);
    chk("R11 irq low", 32'(irq[2]), 32'h0);
    set_src(2, 8'h00);
    set_src(2, 8'h02);
    chk_rd("R11 next rise", st_a(2), 32'h2);
    wr(st_a(2), 32'h2);
    set_src(2, 8'h00);

    // R12 status write and rise in the same clock
    set_src(0, 8'h01);
    set_src(0, 8'h00);
    src[0 +: NSRC] = 8'h04;
    wr(st_a(0), 32'h1);
    chk_rd("R12 write then event", st_a(0), 32'h4);
    chk("R12 irq", 32'(irq[0]), 32'h1);
    wr(st_a(0), 32'h4);
    set_src(0, 8'h00);

    // R10 unimplemented addresses
    wr(16'h2000, 32'hFFFF_FFFF);
    chk_rd("R10 above window", 16'h2000, 32'h0);
    wr(16'h1008, 32'h1234_5678);
    chk_rd("R10 in-window hole", 16'h1008, 32'h0);
    wr(16'h1300, 32'hFF);
    chk_rd("R10 missing group", 16'h1300, 32'h0);
    wr(16'h3004, 32'hFFFF_FFFF);
    chk_rd("R10 alias ignored", en_a(0), 32'hFF);
    chk("R10 irq untouched", 32'(irq), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule